// File: doc/BRIEF.md
# Radix-4 Prefix Generate/Propagate Cell

This block merges four neighbouring propagate/generate pairs into prefix terms for a wider span. The pairs may describe single bits or groups that an earlier stage has already merged. Input index 0 is the least significant position. Output position k holds the combined pair for the span that runs from position k down to position 0. Position 3 therefore covers the whole four-wide group. Positions 2 and 1 are the lower-anchored partial spans, and position 0 is the lowest input unchanged. Because the partial spans come out directly, every carry inside the group is available after a single AND-OR step once the incoming carry is known.

The cell is the basic element of high-radix prefix adders. One level of cells condenses bits into groups. A further cell condenses those groups and returns the carry into each group. The bits inside each group then resolve against that group carry.

A parameter selects how the span logic is built: a flat sum of products, or a serial chain of two-input merges. Both must give the same result. A second parameter enables the carry outputs. When it is off, the carry vector is held at zero and the carry input is ignored.

Top module: `pg4_prefix_cell`

## Requirements
- R1: `p_pre[3]` is the AND of all four `p_in` bits, and `g_pre[3]` equals g3 | p3&g2 | p3&p2&g1 | p3&p2&p1&g0.
- R2: `p_pre[2]`/`g_pre[2]` are the combined pair for span 2..0, and `p_pre[1]`/`g_pre[1]` are the combined pair for span 1..0, using the same formula form as R1.
- R3: `p_pre[0]` equals `p_in[0]` and `g_pre[0]` equals `g_in[0]`; with all inputs zero, every output is zero.
- R4: every prefix output equals a cascade of two-input merges (g = g_hi | p_hi&g_lo, p = p_hi&p_lo), and the flat (`STYLE`=1) and serial (`STYLE`=0) variants give identical outputs for all inputs.
- R5: with `HAS_CIN`=1, `carry[0]` equals `cin` and `carry[k]` equals `g_pre[k-1] | (p_pre[k-1] & cin)` for k = 1..3.
- R6: with `HAS_CIN`=0, `carry` is all zeros and `cin` has no effect on any output.
- R7: four cells fed with bit pairs (p = a^b, g = a&b) and one carry-enabled cell over their span-3 outputs form a 16-bit adder whose sum and carry-out equal a + b + cin.
- R8: `cin` never changes `p_pre` or `g_pre`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| p_in | input | 4 | Propagate terms of the four input positions, bit 0 least significant |
| g_in | input | 4 | Generate terms of the four input positions, bit 0 least significant |
| cin | input | 1 | Carry entering position 0 (used only when HAS_CIN=1) |
| p_pre | output | 4 | Prefix propagate, bit k covering span k..0 |
| g_pre | output | 4 | Prefix generate, bit k covering span k..0 |
| carry | output | 4 | Carry into position k (all zero when HAS_CIN=0) |

## Verification
The prefix terms and the carry vector are produced from the same set of inputs in the same cycle. The carries must agree with the prefix terms while the carry input is free to change. The sweep provokes this by stepping through every propagate/generate pattern twice, once with the carry low and once with it high. Each time, it checks that the carries follow the span terms computed arithmetically in the bench, and that the prefix outputs seen with the carry high match those stored for the same pattern with the carry low. The 16-bit chain then checks the same overlap end to end. Group carries from the upper cell must feed the lower cells without disturbing their span terms, and the sums are judged against plain integer addition, including full-length carry runs.

// File: rtl/pg4_pkg.sv
package pg4_pkg;

   localparam int unsigned SPAN = 4;

   typedef struct packed {
      logic p;
      logic g;
   } pg_pair_t;

   // Two-input associative merge: hi covers the upper positions.
   function automatic pg_pair_t pg_join(input pg_pair_t hi, input pg_pair_t lo);
      pg_pair_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

endpackage

// File: rtl/pg4_span.sv
module pg4_span
   import pg4_pkg::*;
#(
   parameter int unsigned STYLE = 1,
   parameter int unsigned W     = SPAN
) (
   input  logic [W-1:0] p_in,
   input  logic [W-1:0] g_in,
   output logic [W-1:0] p_pre,
   output logic [W-1:0] g_pre
);

   if (W < 2) begin : g_bad_w
      $error("pg4_span: W must be at least 2");
   end

   if (STYLE == 0) begin : g_serial
      // Serial chain of two-input merges from the low end upward.
      always_comb begin
         pg_pair_t acc;
         acc      = '{p: p_in[0], g: g_in[0]};
         p_pre[0] = acc.p;
         g_pre[0] = acc.g;
         for (int k = 1; k < W; k++) begin
            acc      = pg_join('{p: p_in[k], g: g_in[k]}, acc);
            p_pre[k] = acc.p;
            g_pre[k] = acc.g;
         end
      end
   end else begin : g_flat
      // Flat sum of products per span: one AND term per source position.
      always_comb begin
         for (int k = 0; k < W; k++) begin
            logic g_acc;
            logic p_acc;
            g_acc = 1'b0;
            p_acc = 1'b1;
            for (int j = 0; j <= k; j++) begin
               logic term;
               term = g_in[j];
               for (int m = j + 1; m <= k; m++) begin
                  term = term & p_in[m];
               end
               g_acc = g_acc | term;
               p_acc = p_acc & p_in[j];
            end
            g_pre[k] = g_acc;
            p_pre[k] = p_acc;
         end
      end
   end

endmodule

// File: rtl/pg4_carry.sv
module pg4_carry #(
   parameter int unsigned HAS_CIN = 1,
   parameter int unsigned W       = 4
) (
   input  logic [W-1:0] p_pre,
   input  logic [W-1:0] g_pre,
   input  logic         cin,
   output logic [W-1:0] carry
);

   if (HAS_CIN != 0) begin : g_on
      assign carry[0] = cin;
      for (genvar k = 1; k < W; k++) begin : g_bit
         assign carry[k] = g_pre[k-1] | (p_pre[k-1] & cin);
      end
      logic unused_top;
      assign unused_top = p_pre[W-1] ^ g_pre[W-1];
   end else begin : g_off
      assign carry = '0;
      logic unused_all;
      assign unused_all = ^{cin, p_pre, g_pre};
   end

endmodule

// File: rtl/pg4_prefix_cell.sv
module pg4_prefix_cell
   import pg4_pkg::*;
#(
   parameter int unsigned STYLE   = 1,
   parameter int unsigned HAS_CIN = 1
) (
   input  logic [3:0] p_in,
   input  logic [3:0] g_in,
   input  logic       cin,
   output logic [3:0] p_pre,
   output logic [3:0] g_pre,
   output logic [3:0] carry
);

   localparam int unsigned W = SPAN;

   if (W != 4) begin : g_bad_span
      $error("pg4_prefix_cell: span must be 4");
   end
   if (STYLE > 1) begin : g_bad_style
      $error("pg4_prefix_cell: STYLE must be 0 or 1");
   end
   if (HAS_CIN > 1) begin : g_bad_cin
      $error("pg4_prefix_cell: HAS_CIN must be 0 or 1");
   end

   pg4_span #(.STYLE(STYLE), .W(W)) u_span (
      .p_in  (p_in),
      .g_in  (g_in),
      .p_pre (p_pre),
      .g_pre (g_pre)
   );

   pg4_carry #(.HAS_CIN(HAS_CIN), .W(W)) u_carry (
      .p_pre (p_pre),
      .g_pre (g_pre),
      .cin   (cin),
      .carry (carry)
   );

   // Balanced-tree regrouping of the same merges checks the span logic.
   always_comb begin
      pg_pair_t lo2;
      pg_pair_t hi2;
      pg_pair_t all4;
      lo2  = pg_join('{p: p_in[1], g: g_in[1]}, '{p: p_in[0], g: g_in[0]});
      hi2  = pg_join('{p: p_in[3], g: g_in[3]}, '{p: p_in[2], g: g_in[2]});
      all4 = pg_join(hi2, lo2);
      a_r1_span_full: assert (p_pre[3] == all4.p && g_pre[3] == all4.g)
         else $error("R1 full span mismatch");
      a_r2_span_two: assert (p_pre[1] == lo2.p && g_pre[1] == lo2.g)
         else $error("R2 two-wide span mismatch");
      a_r3_low_pass: assert (p_pre[0] == p_in[0] && g_pre[0] == g_in[0])
         else $error("R3 lowest pair altered");
      a_r4_nested_prop: assert (!p_pre[3] || (p_pre[2] && p_pre[1] && p_pre[0]))
         else $error("R4 propagate nesting broken");
   end

   if (HAS_CIN != 0) begin : g_chk_on
      always_comb begin
         a_r5_carry_base: assert (carry[0] == cin)
            else $error("R5 carry[0] differs from cin");
         for (int k = 1; k < 4; k++) begin
            a_r5_carry_gen: assert (!g_pre[k-1] || carry[k])
               else $error("R5 generated carry lost");
            a_r5_carry_prop: assert (!(cin && p_pre[k-1]) || carry[k])
               else $error("R5 propagated carry lost");
         end
      end
   end else begin : g_chk_off
      always_comb begin
         a_r6_carry_off: assert (carry == 4'b0000)
            else $error("R6 carry active while disabled");
      end
   end

endmodule

// File: tb/pg4_chain16.sv
module pg4_chain16 (
   input  logic [15:0] a,
   input  logic [15:0] b,
   input  logic        cin,
   output logic [15:0] sum,
   output logic        cout
);

   localparam int unsigned NGRP = 4;

   logic [15:0]     bp, bg, bc;
   logic [NGRP-1:0] gp, gg, gc, tp, tg;
   logic [3:0]      lp [NGRP];
   logic [3:0]      lg [NGRP];
   logic [3:0]      unused_c [NGRP];

   assign bp = a ^ b;
   assign bg = a & b;

   for (genvar j = 0; j < NGRP; j++) begin : g_l1
      pg4_prefix_cell #(.STYLE(1), .HAS_CIN(0)) u_l1 (
         .p_in  (bp[4*j +: 4]),
         .g_in  (bg[4*j +: 4]),
         .cin   (1'b0),
         .p_pre (lp[j]),
         .g_pre (lg[j]),
         .carry (unused_c[j])
      );
      assign gp[j] = lp[j][3];
      assign gg[j] = lg[j][3];
      for (genvar k = 0; k < 4; k++) begin : g_bit
         if (k == 0) begin : g_first
            assign bc[4*j] = gc[j];
         end else begin : g_rest
            assign bc[4*j+k] = lg[j][k-1] | (lp[j][k-1] & gc[j]);
         end
      end
   end

   pg4_prefix_cell #(.STYLE(0), .HAS_CIN(1)) u_l2 (
      .p_in  (gp),
      .g_in  (gg),
      .cin   (cin),
      .p_pre (tp),
      .g_pre (tg),
      .carry (gc)
   );

   assign sum  = bp ^ bc;
   assign cout = tg[3] | (tp[3] & cin);

endmodule

// File: tb/test_pg4_prefix_cell.sv
module test_pg4_prefix_cell;

   logic clk = 1'b0;
   always #5 clk = ~clk;
   logic rst_n;

   logic [3:0] p_in, g_in;
   logic       cin;
   logic [3:0] m_p, m_g, m_c;
   logic [3:0] s_p, s_g, s_c;
   logic [3:0] n_p, n_g, n_c;

   logic [15:0] a, b, sum;
   logic        ci16, cout;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [3:0] keep_p [256];
   logic [3:0] keep_g [256];

   pg4_prefix_cell #(.STYLE(1), .HAS_CIN(1)) i_pg4_prefix_cell (
      .p_in(p_in), .g_in(g_in), .cin(cin), .p_pre(m_p), .g_pre(m_g), .carry(m_c));
   pg4_prefix_cell #(.STYLE(0), .HAS_CIN(1)) i_serial (
      .p_in(p_in), .g_in(g_in), .cin(cin), .p_pre(s_p), .g_pre(s_g), .carry(s_c));
   pg4_prefix_cell #(.STYLE(1), .HAS_CIN(0)) i_nocin (
      .p_in(p_in), .g_in(g_in), .cin(cin), .p_pre(n_p), .g_pre(n_g), .carry(n_c));
   pg4_chain16 i_chain (.a(a), .b(b), .cin(ci16), .sum(sum), .cout(cout));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Radix-2 cascade from position 0 up to position k: returns {p, g}.
   function automatic logic [1:0] ref_span(input logic [3:0] p, input logic [3:0] g,
                                           input int k);
      logic rp, rg;
      rp = p[0];
      rg = g[0];
      for (int j = 1; j <= k; j++) begin
         rg = g[j] | (p[j] & rg);
         rp = rp & p[j];
      end
      return {rp, rg};
   endfunction

   task automatic add16(input logic [15:0] va, input logic [15:0] vb, input logic vc);
      logic [16:0] exp;
      @(posedge clk);
      a    = va;
      b    = vb;
      ci16 = vc;
      @(negedge clk);
      exp = {1'b0, va} + {1'b0, vb} + {16'd0, vc};
      chk({cout, sum} == exp, "R7 chained 16-bit sum", {15'd0, cout, sum}, {15'd0, exp});
   endtask

   initial begin
      rst_n = 1'b0;
      p_in  = '0;
      g_in  = '0;
      cin   = 1'b0;
      a     = '0;
      b     = '0;
      ci16  = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R3: idle inputs give zero outputs
      chk({m_p, m_g, m_c} == 12'h000, "R3 idle outputs", {20'd0, m_p, m_g, m_c}, 32'd0);
      chk({cout, sum} == 17'd0, "R7 idle chain", {15'd0, cout, sum}, 32'd0);
      rst_n = 1'b1;

      for (int v = 0; v < 512; v++) begin
         logic [3:0] ep, eg, ec;
         @(posedge clk);
         {cin, g_in, p_in} = v[8:0];
         @(negedge clk);
         for (int k = 0; k < 4; k++) begin
            logic [1:0] r;
            r     = ref_span(p_in, g_in, k);
            ep[k] = r[1];
            eg[k] = r[0];
         end
         ec[0] = cin;
         for (int k = 1; k < 4; k++) ec[k] = eg[k-1] | (ep[k-1] & cin);

         chk({m_p[3], m_g[3]} == {ep[3], eg[3]}, "R1 full span",
             {30'd0, m_p[3], m_g[3]}, {30'd0, ep[3], eg[3]});
         chk({m_p[2:1], m_g[2:1]} == {ep[2:1], eg[2:1]}, "R2 partial spans",
             {28'd0, m_p[2:1], m_g[2:1]}, {28'd0, ep[2:1], eg[2:1]});
         chk(m_p[0] == p_in[0] && m_g[0] == g_in[0], "R3 lowest pass-through",
             {30'd0, m_p[0], m_g[0]}, {30'd0, p_in[0], g_in[0]});
         chk(s_p == ep && s_g == eg && s_p == m_p && s_g == m_g, "R4 serial equals flat",
             {24'd0, s_p, s_g}, {24'd0, ep, eg});
         chk(m_c == ec && s_c == ec, "R5 carry vector",
             {24'd0, m_c, s_c}, {24'd0, ec, ec});
         chk(n_c == 4'd0 && n_p == ep && n_g == eg, "R6 carry disabled",
             {20'd0, n_c, n_p, n_g}, {24'd0, ep, eg});
         if (cin == 1'b0) begin
            keep_p[v[7:0]] = m_p;
            keep_g[v[7:0]] = m_g;
         end else begin
            chk(m_p == keep_p[v[7:0]] && m_g == keep_g[v[7:0]], "R8 cin leaves prefix",
                {24'd0, m_p, m_g}, {24'd0, keep_p[v[7:0]], keep_g[v[7:0]]});
         end
      end

      // R7 corners: full carry runs, top-bit carry-out, zero
      add16(16'hFFFF, 16'h0000, 1'b1);
      add16(16'hFFFF, 16'h0001, 1'b0);
      add16(16'hFFFF, 16'hFFFF, 1'b1);
      add16(16'h8000, 16'h8000, 1'b0);
      add16(16'h0FFF, 16'h0000, 1'b1);
      add16(16'h00FF, 16'h0001, 1'b0);
      add16(16'h0000, 16'h0000, 1'b1);
      add16(16'h7FFF, 16'h0001, 1'b0);
      begin
         logic [31:0] lfsr;
         lfsr = 32'h1D2C_3B4A;
         for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            add16(lfsr[15:0], lfsr[31:16], lfsr[7]);
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

endmodule